// File: doc/BRIEF.md
# Split Row Buffer Bank Controller

This block is the per-bank access controller of a two-bit-per-cell nonvolatile memory. Every cell carries a high bit that senses quickly but programs slowly and a low bit that programs quickly but senses slowly. The bits are mapped so that whole 4 KB pages belong to one bit class. Pages of the two classes alternate through the physical address space. A page of the high bits is a fast-read page, and a page of the low bits is a fast-write page.

The bank does not use one wide row buffer. It keeps two half-size open-row trackers, one per bit class, and each one remembers its own open row, a valid flag and a dirty flag. The class of a request picks one of them. A request that hits the selected buffer is served after a short buffer access. A request that misses first writes the old row back if it is dirty, then opens the new row, and then is served. The array time for each of these steps depends on the class.

Requests arrive on a valid/ready port, and the bank holds only one request at a time. The word access itself goes to a simple word port that the surrounding logic, or a behavioural array, serves in the same cycle. Timing is modelled with down-counters.

Top module: `srb_bank_ctrl`

## Requirements
- R1: Address bit `CLASS_BIT` (default 12) picks the page class: 0 is fast-read and 1 is fast-write. The response reports the class on `resp_fw` (1 = fast-write).
- R2: The two buffers are independent. Opening, writing or writing back one class's row never changes the open row, valid flag or dirty flag of the other class.
- R3: A request whose row is open in its class's buffer has `resp_valid` rise `HIT_LAT` (default 2) clock edges after the accepting edge, with `resp_hit` = 1.
- R4: A miss on a clean or invalid buffer has `resp_valid` rise `RD_LAT_FR` + `HIT_LAT` edges after acceptance for a fast-read page (default 10). For a fast-write page it is `RD_LAT_FW` + `HIT_LAT` (default 18). `resp_hit` = 0.
- R5: A miss on a dirty buffer adds a write-back before the open. The write-back costs `WR_LAT_FR` (default 50) for the fast-read buffer and `WR_LAT_FW` (default 42) for the fast-write buffer, so both default totals are 60.
- R6: A write marks the selected buffer dirty and a read does not. A write-back followed by an open leaves that buffer clean.
- R7: `req_ready` is 1 only while idle. It is 0 from the accepting edge until the edge at which `resp_valid` and `resp_ready` are both 1.
- R8: While `resp_valid` is 1 and `resp_ready` is 0, `resp_valid`, `resp_rdata`, `resp_hit` and `resp_fw` hold their values.
- R9: After reset both buffers are invalid and clean, so the first access to each class is a clean miss.
- R10: Each request makes exactly one one-cycle `mem_en` pulse, at the request's address. A read returns the word that `mem_rdata` presents in that cycle. A write drives `req_wdata` on `mem_wdata` with `mem_we` = 1 and echoes that data on `resp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bank idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Response taken |
| resp_rdata | output | DATA_W | Read word, or echoed write data |
| resp_hit | output | 1 | Request hit its class's open row |
| resp_fw | output | 1 | Request addressed a fast-write page |
| mem_en | output | 1 | One-cycle word access strobe |
| mem_we | output | 1 | Word access is a write |
| mem_addr | output | ADDR_W | Word access address |
| mem_wdata | output | DATA_W | Word access write data |
| mem_rdata | input | DATA_W | Word read data, valid in the strobe cycle |

## Verification
On every cycle the assertions check the handshake rules and the buffer bookkeeping:
- `req_ready` drops after an acceptance.
- The response is held while it is stalled.
- The word strobe lasts one cycle.
- An opened buffer is clean, a write marks it dirty, and a write-back only ever happens on a dirty buffer.
- A response reports a hit exactly when it came `HIT_LAT` edges after acceptance.

Only the bench's scenarios can show that the miss latencies are right for each class and each dirty state, that one class's traffic leaves the other buffer's row open, and that data written through one buffer reads back later through a fresh open.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WBACK = 3'd1,
        ST_OPEN  = 3'd2,
        ST_SERVE = 3'd3,
        ST_RESP  = 3'd4
    } bank_state_e;

    typedef enum logic {
        PC_FAST_READ  = 1'b0,
        PC_FAST_WRITE = 1'b1
    } page_class_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srb_addr_split.sv
module srb_addr_split
    import srb_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int CLASS_BIT = 12,
    localparam int ROW_W    = ADDR_W - CLASS_BIT - 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output page_class_e       cls_o,
    output logic [ROW_W-1:0]  row_o
);

    // The page class comes from one address bit; the row is everything above it.
    assign cls_o = page_class_e'(addr_i[CLASS_BIT]);
    assign row_o = addr_i[ADDR_W-1:CLASS_BIT+1];

endmodule

// File: rtl/srb_lat_sel.sv
module srb_lat_sel
    import srb_pkg::*;
#(
    parameter int RD_LAT_FR = 8,
    parameter int RD_LAT_FW = 16,
    parameter int WR_LAT_FR = 50,
    parameter int WR_LAT_FW = 42,
    parameter int CNT_W     = 6
) (
    input  page_class_e      cls_i,
    output logic [CNT_W-1:0] rd_load_o,
    output logic [CNT_W-1:0] wr_load_o
);

    // Counter load values are the latency minus one: the count hits zero on the last cycle.
    localparam logic [CNT_W-1:0] RD_LOAD_FR = CNT_W'(RD_LAT_FR - 1);
    localparam logic [CNT_W-1:0] RD_LOAD_FW = CNT_W'(RD_LAT_FW - 1);
    localparam logic [CNT_W-1:0] WR_LOAD_FR = CNT_W'(WR_LAT_FR - 1);
    localparam logic [CNT_W-1:0] WR_LOAD_FW = CNT_W'(WR_LAT_FW - 1);

    always_comb begin
        if (cls_i == PC_FAST_WRITE) begin
            rd_load_o = RD_LOAD_FW;
            wr_load_o = WR_LOAD_FW;
        end else begin
            rd_load_o = RD_LOAD_FR;
            wr_load_o = WR_LOAD_FR;
        end
    end

endmodule

// File: rtl/srb_rowbuf_tag.sv
module srb_rowbuf_tag #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] lookup_row_i,
    input  logic             open_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic             wb_done_i,
    input  logic             mark_dirty_i,
    output logic             hit_o,
    output logic             dirty_o
);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [ROW_W-1:0] row;
    } tag_t;

    tag_t tag_q, tag_d;

    always_comb begin
        tag_d = tag_q;
        if (wb_done_i) begin
            tag_d.dirty = 1'b0;
        end
        if (open_i) begin
            tag_d.valid = 1'b1;
            tag_d.dirty = 1'b0;
            tag_d.row   = open_row_i;
        end
        if (mark_dirty_i) begin
            tag_d.dirty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            tag_q <= tag_d;
        end
    end

    assign hit_o   = tag_q.valid && (tag_q.row == lookup_row_i);
    assign dirty_o = tag_q.dirty;

    // R6
    open_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && !mark_dirty_i) |=> !dirty_o);

    // R6
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty_i |=> dirty_o);

    // R5
    wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done_i |-> dirty_o);

endmodule

// File: rtl/srb_bank_ctrl.sv
module srb_bank_ctrl
    import srb_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int CLASS_BIT = 12,
    parameter int HIT_LAT   = 2,
    parameter int RD_LAT_FR = 8,
    parameter int RD_LAT_FW = 16,
    parameter int WR_LAT_FR = 50,
    parameter int WR_LAT_FW = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_hit,
    output logic              resp_fw,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int ROW_W   = ADDR_W - CLASS_BIT - 1;
    localparam int N_BUF   = 2;
    localparam int MAX_LAT = max2(max2(max2(RD_LAT_FR, RD_LAT_FW),
                                       max2(WR_LAT_FR, WR_LAT_FW)), HIT_LAT);
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [CNT_W-1:0] HIT_LOAD = CNT_W'(HIT_LAT - 1);

    typedef struct packed {
        bank_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              hit;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t r_q, r_d;

    page_class_e      req_cls, cur_cls, lat_cls;
    logic [ROW_W-1:0] req_row, cur_row;
    logic [CNT_W-1:0] rd_load, wr_load;
    logic [N_BUF-1:0] buf_hit, buf_dirty, buf_open, buf_wb, buf_mark;
    logic             req_sel, cnt_done;

    // Decode for the incoming request (lookup) and for the held request (open/write-back).
    srb_addr_split #(.ADDR_W(ADDR_W), .CLASS_BIT(CLASS_BIT)) u_req_split (
        .addr_i (req_addr),
        .cls_o  (req_cls),
        .row_o  (req_row)
    );

    srb_addr_split #(.ADDR_W(ADDR_W), .CLASS_BIT(CLASS_BIT)) u_cur_split (
        .addr_i (r_q.addr),
        .cls_o  (cur_cls),
        .row_o  (cur_row)
    );

    assign lat_cls = (r_q.st == ST_IDLE) ? req_cls : cur_cls;

    srb_lat_sel #(
        .RD_LAT_FR (RD_LAT_FR),
        .RD_LAT_FW (RD_LAT_FW),
        .WR_LAT_FR (WR_LAT_FR),
        .WR_LAT_FW (WR_LAT_FW),
        .CNT_W     (CNT_W)
    ) u_lat (
        .cls_i     (lat_cls),
        .rd_load_o (rd_load),
        .wr_load_o (wr_load)
    );

    assign cnt_done = (r_q.cnt == '0);
    assign req_sel  = (req_cls == PC_FAST_WRITE);

    // One tag tracker per bit class; the held request's class steers the updates.
    for (genvar g = 0; g < N_BUF; g++) begin : g_buf
        logic sel_cur;
        assign sel_cur     = (cur_cls == page_class_e'(g));
        assign buf_open[g] = (r_q.st == ST_OPEN)  && cnt_done && sel_cur;
        assign buf_wb[g]   = (r_q.st == ST_WBACK) && cnt_done && sel_cur;
        assign buf_mark[g] = (r_q.st == ST_SERVE) && cnt_done && sel_cur && r_q.we;

        srb_rowbuf_tag #(.ROW_W(ROW_W)) u_tag (
            .clk          (clk),
            .rst_n        (rst_n),
            .lookup_row_i (req_row),
            .open_i       (buf_open[g]),
            .open_row_i   (cur_row),
            .wb_done_i    (buf_wb[g]),
            .mark_dirty_i (buf_mark[g]),
            .hit_o        (buf_hit[g]),
            .dirty_o      (buf_dirty[g])
        );
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.we    = req_we;
                    r_d.wdata = req_wdata;
                    r_d.hit   = buf_hit[req_sel];
                    if (buf_hit[req_sel]) begin
                        r_d.st  = ST_SERVE;
                        r_d.cnt = HIT_LOAD;
                    end else if (buf_dirty[req_sel]) begin
                        r_d.st  = ST_WBACK;
                        r_d.cnt = wr_load;
                    end else begin
                        r_d.st  = ST_OPEN;
                        r_d.cnt = rd_load;
                    end
                end
            end
            ST_WBACK: begin
                if (cnt_done) begin
                    r_d.st  = ST_OPEN;
                    r_d.cnt = rd_load;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_OPEN: begin
                if (cnt_done) begin
                    r_d.st  = ST_SERVE;
                    r_d.cnt = HIT_LOAD;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SERVE: begin
                if (cnt_done) begin
                    r_d.st    = ST_RESP;
                    r_d.rdata = r_q.we ? r_q.wdata : mem_rdata;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RESP: begin
                if (resp_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign resp_valid = (r_q.st == ST_RESP);
    assign resp_rdata = r_q.rdata;
    assign resp_hit   = r_q.hit;
    assign resp_fw    = (cur_cls == PC_FAST_WRITE);
    assign mem_en     = (r_q.st == ST_SERVE) && cnt_done;
    assign mem_we     = r_q.we;
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.wdata;

    // Checker state: edges elapsed since the accepting edge.
    logic [15:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (req_valid && req_ready) begin
            age_q <= '0;
        end else if (!req_ready && !resp_valid && (age_q != 16'hFFFF)) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)
                                         && $stable(resp_hit) && $stable(resp_fw)));

    // R10
    mem_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

    // R3
    hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> (resp_hit == (age_q == 16'(HIT_LAT))));

endmodule

// File: tb/srb_bank_ctrl_tb.sv
module srb_bank_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_we = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              resp_valid;
    logic              resp_ready = 1'b0;
    logic [DATA_W-1:0] resp_rdata;
    logic              resp_hit, resp_fw;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    srb_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
        .resp_hit(resp_hit), .resp_fw(resp_fw),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Behavioural array: bits 14:13 row, 12 class, 4:2 word.
    function automatic int widx(input logic [ADDR_W-1:0] a);
        return int'({a[14:13], a[12], a[4:2]});
    endfunction

    logic [DATA_W-1:0] arr [64];
    assign mem_rdata = arr[widx(mem_addr)];

    int strobes = 0;
    always @(posedge clk) begin
        if (mem_en) begin
            strobes <= strobes + 1;
            if (mem_we) arr[widx(mem_addr)] <= mem_wdata;
        end
    end

    // Reference model state.
    logic [DATA_W-1:0] model_mem [64];
    bit                m_valid [2];
    bit                m_dirty [2];
    int                m_row   [2];

    int  compared = 0;
    int  mismatched = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_txn(input logic [ADDR_W-1:0] a, input bit we,
                          input logic [DATA_W-1:0] wd, input int hold, input string tag);
        int c, r, lat, n, s0;
        bit ehit;
        logic [DATA_W-1:0] exp_rd, held;
        string ltag;
        c = int'(a[12]);
        r = int'(a[ADDR_W-1:13]);
        ehit = m_valid[c] && (m_row[c] == r);
        if (ehit) begin
            lat = 2; ltag = "R3";
        end else begin
            lat = (c == 1) ? 18 : 10;
            ltag = "R4";
            if (m_dirty[c]) begin
                lat += (c == 1) ? 42 : 50;
                ltag = "R5";
                m_dirty[c] = 0;
            end
            m_valid[c] = 1; m_row[c] = r;
        end
        if (tag != "") ltag = tag;
        if (we) begin
            exp_rd = wd; model_mem[widx(a)] = wd; m_dirty[c] = 1;
        end else begin
            exp_rd = model_mem[widx(a)];
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R7", "ready before request", req_ready, 1);
        s0 = strobes;
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7", "ready after accept", req_ready, 0);
        chk(resp_valid == 1'b0, ltag, "resp_valid at accept", resp_valid, 0);
        for (n = 1; n <= lat; n++) begin
            @(negedge clk);
            chk(resp_valid == (n == lat), ltag, "resp_valid timing", resp_valid, (n == lat));
            chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
        end
        chk(resp_hit == ehit, ltag, "resp_hit", resp_hit, ehit);
        chk(resp_fw == a[12], "R1", "resp_fw", resp_fw, a[12]);
        chk(resp_rdata == exp_rd, "R10", "resp_rdata", resp_rdata, exp_rd);
        chk(strobes - s0 == 1, "R10", "mem_en pulses", strobes - s0, 1);
        held = resp_rdata;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(resp_valid == 1'b1 && resp_rdata == held, "R8", "held response", resp_rdata, held);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        chk(resp_valid == 1'b0, "R7", "resp_valid after handshake", resp_valid, 0);
        chk(req_ready == 1'b1, "R7", "ready after handshake", req_ready, 1);
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int row, input int cls, input int col);
        logic [ADDR_W-1:0] a;
        a = '0;
        a[14:13] = 2'(row);
        a[12]    = 1'(cls);
        a[4:2]   = 3'(col);
        return a;
    endfunction

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 64; i++) begin
            arr[i]       = 32'hC0DE_0000 + 32'(i * 7);
            model_mem[i] = 32'hC0DE_0000 + 32'(i * 7);
        end
        for (int k = 0; k < 2; k++) begin
            m_valid[k] = 0; m_dirty[k] = 0; m_row[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R9: idle outputs during reset
        chk(req_ready == 1'b1 && resp_valid == 1'b0, "R9", "reset outputs", {req_ready, resp_valid}, 2);
        chk(mem_en == 1'b0, "R9", "reset mem_en", mem_en, 0);
        rst_n = 1'b1;

        do_txn(mk(0, 0, 1), 0, '0, 0, "R9");           // first FR access: clean miss
        do_txn(mk(0, 0, 2), 0, '0, 0, "R3");           // hit
        do_txn(mk(0, 0, 2), 1, 32'h1111_AAAA, 0, "R3"); // write hit, FR dirty
        do_txn(mk(0, 1, 1), 0, '0, 0, "R9");           // first FW access: clean miss
        do_txn(mk(0, 0, 2), 0, '0, 0, "R2");           // FR row still open
        do_txn(mk(0, 1, 3), 1, 32'h2222_BBBB, 3, "R8"); // FW write hit, stalled response
        do_txn(mk(1, 0, 0), 0, '0, 0, "R5");           // FR dirty miss
        do_txn(mk(1, 1, 3), 0, '0, 1, "R5");           // FW dirty miss
        do_txn(mk(0, 1, 3), 0, '0, 0, "R6");           // clean again after write-back
        do_txn(mk(0, 0, 2), 0, '0, 0, "R6");           // data survived write-back

        lfsr = 16'hACE1;
        for (int t = 0; t < 40; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_txn(mk(int'(lfsr[1:0]) & 1, int'(lfsr[2]), int'(lfsr[5:3])),
                   lfsr[6], {16'h5A00, lfsr}, int'(lfsr[8:7]) % 3, "");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule